// File: doc/BRIEF.md
# Three-Wire Coded Serial Slave

This block is the device-side end of a three-pin link to a small microcontroller. The controller sets a two-bit mode code and then raises a serial clock. The high code bit has a pin of its own. The low code bit shares a bidirectional pin with the data. Each rising serial clock makes the block do one of three things: shift a command bit in, shift a status bit out, or execute the command held in the shift register. Every input is brought into the fast system clock domain through synchronizer flops, so all actions are ordinary single-clock logic.

The mode code is captured only when the synchronized code-high line changes. The controller must therefore toggle code-high to select a new mode. Changing the shared pin alone does not switch modes. Executing a command may set or clear a ready flag. A toggle of the master-side write strobe, or a reset, clears that flag, and the clear wins over a simultaneous execute. The status byte is preloaded through a parallel load port.

Top module: `tri_wire_slave`

## Requirements
- R1: After reset, `ready_o` is 0, `cmd_o` is all zeros, and the shared pin is released (high impedance).
- R2: The mode code is latched as {code-high, shared pin} only when synchronized code-high changes. A change of the shared pin while code-high stays steady leaves the mode as it was.
- R3: In shift-in mode (code-high 0), each rising serial clock puts the shared pin's value into bit 12 of `cmd_o`, and every other bit moves one place toward bit 0.
- R4: In shift-out mode (code 11), the shared pin drives bit 7 of the output byte. Each rising serial clock shifts the byte left with a 0 entering bit 0. `load_i` loads `load_data_i` into the byte. In this mode `cmd_o` and `ready_o` do not change.
- R5: In every mode other than 11 the block releases the shared pin to high impedance.
- R6: In execute mode (code 10), a rising serial clock with `cmd_o[12]`=0 and `cmd_o[11:10]`=00 sets `ready_o` to 1.
- R7: In execute mode, a rising serial clock with `cmd_o[12]`=0 and `cmd_o[11:10]`=01 copies `cmd_o[9]` into `ready_o`.
- R8: An execute with `cmd_o[12]`=1, or with `cmd_o[11:10]` equal to 10 or 11, leaves `ready_o` unchanged.
- R9: Either edge of `wr_strobe_i` clears `ready_o`, and this clear takes priority over an execute in the same cycle.
- R10: An action takes effect on the third rising system clock edge after the serial clock rises. A falling serial clock causes no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the controller (asynchronous) |
| code_hi_i | input | 1 | High bit of the mode code (asynchronous) |
| wr_strobe_i | input | 1 | Master-side write strobe; any toggle clears ready |
| load_i | input | 1 | Load the output byte |
| load_data_i | input | 8 | Byte to load for shift-out |
| code_lo_io | inout | 1 | Low code bit, serial data in, serial data out |
| ready_o | output | 1 | Ready flag |
| cmd_o | output | 13 | Command shift register contents |

## Verification
A serial clock rise, a code-high change and a strobe toggle each take effect on the third system clock edge after the input moves. This is two synchronizer stages plus the action register. One directed sequence checks this exact cycle: the flag is still old after two edges and new after the third. All other checks wait at least five system clocks after the stimulus and sample on the falling clock edge, so they never land in the settling window. The serial clock is held high and low for five system clocks each, and the data pin is set two clocks before the rise.

// File: rtl/tri_wire_slave.sv
module tri_wire_slave #(
  parameter int CMD_W = 13,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             code_hi_i,
  input  logic             wr_strobe_i,
  input  logic             load_i,
  input  logic [OUT_W-1:0] load_data_i,
  inout  wire              code_lo_io,
  output logic             ready_o,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int TOP   = CMD_W - 1;
  localparam int OP_HI = CMD_W - 2;
  localparam int OP_LO = CMD_W - 3;
  localparam int ARG   = CMD_W - 4;
  localparam logic [1:0] M_EXEC = 2'b10;
  localparam logic [1:0] M_OUT  = 2'b11;

  logic [2:0]       sclk_q, hi_q, wr_q;
  logic [1:0]       pad_q, code_q;
  logic [OUT_W-1:0] out_q;
  logic [CMD_W-1:0] cmd_q;
  logic             ready_q;

  wire pulse  = sclk_q[1] & ~sclk_q[2];
  wire hi_chg = hi_q[1] ^ hi_q[2];
  wire wr_chg = wr_q[1] ^ wr_q[2];
  wire do_in  = pulse & ~code_q[1];
  wire do_out = pulse & (code_q == M_OUT);
  wire do_ex  = pulse & (code_q == M_EXEC) & ~cmd_q[TOP];

  assign code_lo_io = (code_q == M_OUT) ? out_q[OUT_W-1] : 1'bz;
  assign ready_o    = ready_q;
  assign cmd_o      = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      hi_q   <= '0;
      wr_q   <= '0;
      pad_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk_i};
      hi_q   <= {hi_q[1:0], code_hi_i};
      wr_q   <= {wr_q[1:0], wr_strobe_i};
      pad_q  <= {pad_q[0], code_lo_io};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         code_q <= 2'b00;
    else if (hi_chg) code_q <= {hi_q[1], pad_q[1]};
  end

  always_ff @(posedge clk) begin
    if (rst)        cmd_q <= '0;
    else if (do_in) cmd_q <= {pad_q[1], cmd_q[TOP:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (load_i) out_q <= load_data_i;
    else if (do_out) out_q <= {out_q[OUT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || wr_chg) ready_q <= 1'b0;
    else if (do_ex) begin
      if (cmd_q[OP_HI:OP_LO] == 2'b00)      ready_q <= 1'b1;
      else if (cmd_q[OP_HI:OP_LO] == 2'b01) ready_q <= cmd_q[ARG];
    end
  end

  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_q[1] == hi_q[2]) |=> $stable(code_q));

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && !code_q[1]) |=> (cmd_q[TOP-1:0] == $past(cmd_q[TOP:1])));

  // R6
  exec_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && code_q == M_EXEC && cmd_q[TOP:OP_LO] == 3'b000 && wr_q[1] == wr_q[2]) |=> ready_q);

  // R9
  strobe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_q[1] != wr_q[2]) |=> !ready_q);

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(pulse && code_q == M_EXEC) && wr_q[1] == wr_q[2]) |=> $stable(ready_q));
endmodule

// File: tb/tri_wire_slave_tb_top.sv
`timescale 1ns/1ps
module tri_wire_slave_tb_top;
  logic clk = 0, rst = 1;
  logic ser = 0, hi = 0, wr = 0, ld = 0;
  logic [7:0] ld_data = 0;
  logic tb_en = 0, tb_val = 0;
  wire pad;
  logic ready;
  logic [12:0] cmd;
  int checks = 0, errors = 0, mode = 0;
  logic exp_ready;

  assign pad = tb_en ? tb_val : 1'bz;
  pullup (pad);

  always #2 clk = ~clk;

  tri_wire_slave dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(ser), .code_hi_i(hi), .wr_strobe_i(wr),
    .load_i(ld), .load_data_i(ld_data), .code_lo_io(pad),
    .ready_o(ready), .cmd_o(cmd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    ser = 1; cyc(5); ser = 0; cyc(5);
  endtask

  task automatic go_in();
    tb_en = 0; hi = 0; cyc(6); tb_en = 1; tb_val = 0; mode = 0;
  endtask

  task automatic go_exec();
    if (mode != 0) go_in();
    tb_en = 1; tb_val = 0; hi = 1; cyc(6); mode = 2;
  endtask

  task automatic go_out();
    if (mode != 0) go_in();
    tb_en = 1; tb_val = 1; hi = 1; cyc(6); tb_en = 0; cyc(2); mode = 3;
  endtask

  task automatic send_bit(input logic b);
    tb_val = b; cyc(2); pulse();
  endtask

  task automatic send_word(input logic [12:0] w);
    for (int i = 0; i < 13; i++) send_bit(w[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      v[i] = pad;
      pulse();
    end
  endtask

  task automatic toggle_wr();
    wr = ~wr; cyc(6);
  endtask

  task automatic load_out(input logic [7:0] b);
    ld_data = b; ld = 1; cyc(1); ld = 0; cyc(1);
  endtask

  function automatic logic model_exec(input logic prev, input logic [12:0] w);
    if (w[12]) return prev;
    case (w[11:10])
      2'b00:   return 1'b1;
      2'b01:   return w[9];
      default: return prev;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] w;
    logic [7:0]  b, rb;
    string       tag;
    void'($urandom(32'd77));
    cyc(4); rst = 0; cyc(2);

    // R1 reset state
    chk(ready === 1'b0, "R1 ready", ready, 0);
    chk(cmd === 13'h0, "R1 cmd", cmd, 0);
    chk(pad === 1'b1, "R1 pad released", pad, 1);

    // R3 single bits
    go_in();
    send_bit(1);
    chk(cmd === 13'h1000, "R3 first bit", cmd, 13'h1000);
    send_bit(0);
    chk(cmd === 13'h0800, "R3 second bit", cmd, 13'h0800);

    // R10 exact latency
    send_word(13'h0000);
    chk(cmd === 13'h0000, "R3 zero word", cmd, 0);
    go_exec();
    chk(ready === 1'b0, "R6 before execute", ready, 0);
    ser = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(ready === 1'b0, "R10 not before third edge", ready, 0);
    @(negedge clk);
    chk(ready === 1'b1, "R10 at third edge", ready, 1);
    ser = 0; cyc(6);
    chk(ready === 1'b1 && cmd === 13'h0, "R10 falling edge no action", {cmd, ready}, 1);

    // R9 priority over execute
    ser = 1; wr = ~wr; cyc(8);
    chk(ready === 1'b0, "R9 clear beats execute", ready, 0);
    ser = 0; cyc(5);
    pulse();
    chk(ready === 1'b1, "R6 execute op 00", ready, 1);
    toggle_wr();
    chk(ready === 1'b0, "R9 strobe other edge", ready, 0);

    // R2 shared pin change alone does not switch mode
    tb_val = 1; cyc(6);
    pulse();
    chk(ready === 1'b1, "R2 still execute mode", ready, 1);
    tb_val = 0;

    // R7
    go_in(); send_word(13'h0400);
    go_exec(); pulse();
    chk(ready === 1'b0, "R7 arg 0", ready, 0);
    go_in(); send_word(13'h0600);
    go_exec(); pulse();
    chk(ready === 1'b1, "R7 arg 1", ready, 1);

    // R8
    go_in(); send_word(13'h1000);
    go_exec(); pulse();
    chk(ready === 1'b1, "R8 top bit set holds 1", ready, 1);
    toggle_wr();
    go_in(); send_word(13'h0800);
    go_exec(); pulse();
    chk(ready === 1'b0, "R8 op 10 holds 0", ready, 0);
    go_in(); send_word(13'h0C00);
    go_exec(); pulse();
    chk(ready === 1'b0, "R8 op 11 holds 0", ready, 0);

    // R5 release in shift-in and execute modes
    go_in(); tb_en = 0; cyc(3);
    chk(pad === 1'b1, "R5 released in shift-in", pad, 1);
    go_exec(); tb_en = 0; cyc(3);
    chk(pad === 1'b1, "R5 released in execute", pad, 1);

    // R4 drive, zero fill, load
    load_out(8'h00);
    go_out();
    chk(pad === 1'b0, "R4 drives low bit", pad, 0);
    load_out(8'hFF); cyc(2);
    chk(pad === 1'b1, "R4 load visible", pad, 1);
    for (int i = 0; i < 8; i++) pulse();
    chk(pad === 1'b0, "R4 zero fill", pad, 0);

    // random mix
    exp_ready = ready;
    for (int it = 0; it < 30; it++) begin
      w = 13'($urandom);
      case ($urandom % 4)
        0: w[12:10] = 3'b000;
        1: w[12:10] = 3'b001;
        default: ;
      endcase
      go_in(); send_word(w);
      chk(cmd === w, "R3 random word", cmd, w);
      if ($urandom % 3 == 0) begin
        toggle_wr(); exp_ready = 0;
        chk(ready === 1'b0, "R9 random clear", ready, 0);
      end
      go_exec(); pulse();
      exp_ready = model_exec(exp_ready, w);
      tag = w[12] ? "R8 random" : (w[11] ? "R8 random" : (w[10] ? "R7 random" : "R6 random"));
      chk(ready === exp_ready, tag, ready, exp_ready);
      b = 8'($urandom);
      load_out(b);
      go_out();
      read_byte(rb);
      chk(rb === b, "R4 random byte", rb, b);
      chk(cmd === w && ready === exp_ready, "R4 state held in shift-out", {cmd, ready}, {w, exp_ready});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule